// File: doc/BRIEF.md
# SCSI Controller Register Bank

This block is the 16-bit register file that sits between a host's memory-mapped port and the command engine of a small SCSI bus controller. The host reaches it through one word-aligned address, a write strobe, write data and a combinational read-data path. It stores the diagnostic, control, ID, selector, data, DMA-mode, command and diagnostic-control words. Each of these applies a fixed mask on write. It also keeps two status words, the link status word and the transfer status word, whose bits fall into three kinds: event bits the host clears by writing a one, bits only hardware can change, and plain bits.

The command engine raises status bits through two set-strobe buses. Two summary bits are derived from the status words every cycle: a link-event summary and a transfer-event summary. Both summary bits appear in both status words. A single level interrupt output is driven from the summary bits and an enable bit in the control word. The ID the selection detector reports comes in on a port and can be read through the bank, but it cannot be written.

Top module: `scsi_regbank`

## Requirements
- R1: A write whose byte address has bit 1 or bit 0 set changes no register. A read at such an address returns 0x0000.
- R2: The words are mapped at these byte offsets: 0x00 diagnostic data, 0x0C control, 0x10 own ID, 0x14 target selector, 0x18 detector ID, 0x20 data, 0x24 DMA mode, 0x48 link status, 0x4C transfer status, 0x50 command, 0x54 diagnostic control. Diagnostic data, control and diagnostic control store all 16 bits. Reads at any other aligned offset return 0x0000, and writes there change nothing.
- R3: Own ID (0x10) and target selector (0x14) keep write bits [2:0] only. DMA mode (0x24) keeps bits [1:0] only, and data (0x20) keeps bits [7:0] only. All other bits of these words read 0.
- R4: The detector ID word (0x18) reads as the 3-bit `det_id` input with zeros above it. Writes to 0x18 change nothing.
- R5: In link status (0x48), a write of 1 clears bit 13, 12, 11, 9, 8, 7 or 3, and a write of 0 to those bits leaves them unchanged. Bits 6, 5, 4, 2, 1 and 0 are unaffected by writes. Bit 10 takes the written value.
- R6: In transfer status (0x4C), a write of 1 clears bit 13, 11, 10, 4 or 3, and a write of 0 leaves them unchanged. Bits 2, 1 and 0 are unaffected by writes. Bits 12 and 9..5 take the written value.
- R7: The link summary (bit 15 of both status words) is the OR of link status bits 13 (bus reset), 12 (bus error), 11 (out-of-phase), 9 (buffer condition), 8 (link done) and 3 (state change). No other link bit affects it.
- R8: The transfer summary (bit 14 of both status words) is the OR of transfer status bits 4 (phase mismatch), 11 (input buffer full), 10 (transmit buffer empty) and 13 (DMA done). Bit 3 and the other transfer bits do not affect it.
- R9: Both summary bits read identically from 0x48 and 0x4C. They reflect the status bits after the same clock edge that changed them. Writes to bits 15 and 14 of either status word have no effect.
- R10: `irq` is high exactly when control bit 0 (interrupt enable) is 1 and either summary bit is 1.
- R11: Command bit 14 (reset request) is never stored and always reads 0. The other 15 command bits store the written value.
- R12: A set strobe on `link_set` or `xfer_set` bit n (n < 14) sets that status bit at the next clock edge. A set wins over a write-one-to-clear of the same bit in the same cycle.
- R13: After reset, every stored word and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| link_set | input | 16 | Set strobes for link status bits [13:0] |
| xfer_set | input | 16 | Set strobes for transfer status bits [13:0] |
| det_id | input | 3 | Target ID reported by the selection detector |
| irq | output | 1 | Level interrupt request |

## Verification
The write masks are tried with all-ones patterns and with mixed patterns such as 0x00AD and 0x1237. These show which bits each word keeps, and they separate a truncating mask from a plain store. The status words are written with all-ones, all-zeros, single-bit and summary-bit patterns. These distinguish clear-on-one from store-written-value and from read-only behaviour, including a write of 0 to a pending event bit. Each summary event bit is raised alone, and a non-summary bit is raised next to them, so the exact OR set behind each summary bit and behind `irq` is pinned down. A set strobe that collides with a clear of the same bit shows the priority, and misaligned and unmapped accesses show that nothing is disturbed.

// File: rtl/scsi_regbank_pkg.sv
package scsi_regbank_pkg;

   localparam int WORD_W    = 16;
   localparam int NUM_PLAIN = 8;

   // plain-word slots, decoded by byte offset
   localparam int SLOT_DIAG = 0;
   localparam int SLOT_CTRL = 1;
   localparam int SLOT_OWN  = 2;
   localparam int SLOT_TSEL = 3;
   localparam int SLOT_DATA = 4;
   localparam int SLOT_DMA  = 5;
   localparam int SLOT_CMD  = 6;
   localparam int SLOT_DCTL = 7;

   localparam logic [7:0] PLAIN_OFF [NUM_PLAIN] =
      '{8'h00, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h24, 8'h50, 8'h54};
   // bit 14 of the command word is the reset request and is never kept
   localparam logic [WORD_W-1:0] PLAIN_KEEP [NUM_PLAIN] =
      '{16'hFFFF, 16'hFFFF, 16'h0007, 16'h0007, 16'h00FF, 16'h0003, 16'hBFFF, 16'hFFFF};

   localparam logic [7:0] OFF_DET  = 8'h18;
   localparam logic [7:0] OFF_LINK = 8'h48;
   localparam logic [7:0] OFF_XFER = 8'h4C;

   localparam logic [WORD_W-1:0] LINK_RO  = 16'h3BF7;
   localparam logic [WORD_W-1:0] LINK_W1C = 16'h3B88;
   localparam logic [WORD_W-1:0] LINK_EVT = 16'h3B08;
   localparam logic [WORD_W-1:0] XFER_RO  = 16'h0C17;
   localparam logic [WORD_W-1:0] XFER_W1C = 16'h2C18;
   localparam logic [WORD_W-1:0] XFER_EVT = 16'h2C10;

   localparam int LINK_SUM_BIT = 15;
   localparam int XFER_SUM_BIT = 14;
   localparam logic [WORD_W-1:0] SUM_MASK = 16'hC000;
   localparam int IE_BIT = 0;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
   import scsi_regbank_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic                 aligned,
   output logic [NUM_PLAIN-1:0] plain_hit,
   output logic                 link_hit,
   output logic                 xfer_hit,
   output logic                 det_hit
);
   initial assert (ADDR_W >= 8) else $error("regbank_decode: ADDR_W must be at least 8");

   always_comb begin
      aligned = (addr[1:0] == 2'b00);
      for (int i = 0; i < NUM_PLAIN; i++)
         plain_hit[i] = aligned && (addr == ADDR_W'(PLAIN_OFF[i]));
      link_hit = aligned && (addr == ADDR_W'(OFF_LINK));
      xfer_hit = aligned && (addr == ADDR_W'(OFF_XFER));
      det_hit  = aligned && (addr == ADDR_W'(OFF_DET));
   end
endmodule

// File: rtl/regbank_field.sv
module regbank_field #(
   parameter int               DATA_W = 16,
   parameter logic [DATA_W-1:0] KEEP  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   initial assert (DATA_W > 0) else $error("regbank_field: DATA_W must be positive");

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & KEEP;
   end
endmodule

// File: rtl/regbank_status.sv
module regbank_status #(
   parameter int               DATA_W   = 16,
   parameter logic [DATA_W-1:0] RO_MASK  = '0,
   parameter logic [DATA_W-1:0] W1C_MASK = '0,
   parameter logic [DATA_W-1:0] EVT_MASK = '0,
   parameter logic [DATA_W-1:0] SUM_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] set,
   output logic [DATA_W-1:0] q,
   output logic              evt
);
   localparam logic [DATA_W-1:0] PLAIN   = ~(RO_MASK | W1C_MASK | SUM_MASK);
   localparam logic [DATA_W-1:0] RO_ONLY = RO_MASK & ~W1C_MASK & ~SUM_MASK;

   initial assert ((EVT_MASK & SUM_MASK) == '0)
      else $error("regbank_status: summary bits cannot be event bits");

   logic [DATA_W-1:0] after_wr;

   always_comb begin
      if (we) after_wr = ((q & ~PLAIN) & ~(wdata & W1C_MASK)) | (wdata & PLAIN);
      else    after_wr = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (after_wr | set) & ~SUM_MASK;
   end

   assign evt = |(q & EVT_MASK);

   // R5 / R6: a one written to a clear-on-write bit leaves it clear unless set
   assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q & $past(wdata & W1C_MASK & ~set)) == '0));

   // R12: a set strobe always lands, even against a clear
   assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set & ~SUM_MASK)) |=> ((q & $past(set & ~SUM_MASK)) == $past(set & ~SUM_MASK)));

   // R6: read-only bits ignore host writes
   assert_ro_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && set == '0) |=> ((q & RO_ONLY) == ($past(q) & RO_ONLY)));
endmodule

// File: rtl/scsi_regbank.sv
module scsi_regbank
   import scsi_regbank_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = WORD_W,
   parameter int ID_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] link_set,
   input  logic [DATA_W-1:0] xfer_set,
   input  logic [ID_W-1:0]   det_id,
   output logic              irq
);
   initial assert (DATA_W == WORD_W) else $error("scsi_regbank: DATA_W must equal WORD_W");
   initial assert (ID_W <= DATA_W) else $error("scsi_regbank: ID_W too wide");

   logic                 aligned, link_hit, xfer_hit, det_hit;
   logic [NUM_PLAIN-1:0] plain_hit;
   logic [DATA_W-1:0]    plain_q [NUM_PLAIN];
   logic [NUM_PLAIN*DATA_W-1:0] plain_flat;
   logic [DATA_W-1:0]    link_q, xfer_q, sum_word;
   logic                 link_evt, xfer_evt;

   regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .aligned(aligned), .plain_hit(plain_hit),
      .link_hit(link_hit), .xfer_hit(xfer_hit), .det_hit(det_hit)
   );

   for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
      regbank_field #(.DATA_W(DATA_W), .KEEP(PLAIN_KEEP[g])) u_fld (
         .clk(clk), .rst_n(rst_n), .we(bus_wr && plain_hit[g]),
         .wdata(bus_wdata), .q(plain_q[g])
      );
      assign plain_flat[g*DATA_W +: DATA_W] = plain_q[g];
   end

   regbank_status #(.DATA_W(DATA_W), .RO_MASK(LINK_RO), .W1C_MASK(LINK_W1C),
                    .EVT_MASK(LINK_EVT), .SUM_MASK(SUM_MASK)) u_link (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && link_hit), .wdata(bus_wdata),
      .set(link_set), .q(link_q), .evt(link_evt)
   );

   regbank_status #(.DATA_W(DATA_W), .RO_MASK(XFER_RO), .W1C_MASK(XFER_W1C),
                    .EVT_MASK(XFER_EVT), .SUM_MASK(SUM_MASK)) u_xfer (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && xfer_hit), .wdata(bus_wdata),
      .set(xfer_set), .q(xfer_q), .evt(xfer_evt)
   );

   always_comb begin
      sum_word = '0;
      sum_word[LINK_SUM_BIT] = link_evt;
      sum_word[XFER_SUM_BIT] = xfer_evt;
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PLAIN; i++)
         if (plain_hit[i]) bus_rdata = plain_q[i];
      if (link_hit) bus_rdata = link_q | sum_word;
      if (xfer_hit) bus_rdata = xfer_q | sum_word;
      if (det_hit)  bus_rdata = DATA_W'(det_id);
   end

   assign irq = plain_q[SLOT_CTRL][IE_BIT] && (link_evt || xfer_evt);

   // R1: misaligned reads return zero
   assert_misaligned_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

   // R1: misaligned writes disturb no stored word
   assert_misaligned_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !aligned && link_set == '0 && xfer_set == '0)
      |=> ($stable(plain_flat) && $stable(link_q) && $stable(xfer_q)));

   // R4: writes to the detector ID word disturb no stored word
   assert_det_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && det_hit && link_set == '0 && xfer_set == '0)
      |=> ($stable(plain_flat) && $stable(link_q) && $stable(xfer_q)));
endmodule

// File: tb/tb_scsi_regbank.sv
module tb_scsi_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] link_set = '0;
   logic [15:0] xfer_set = '0;
   logic [2:0]  det_id = 3'b101;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   scsi_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_set(link_set),
      .xfer_set(xfer_set), .det_id(det_id), .irq(irq)
   );

   // {req, write addr, write data, read addr, expected read}
   localparam int NV = 14;
   localparam logic [51:0] VEC [NV] = '{
      {4'd3,  8'h10, 16'hFFFF, 8'h10, 16'h0007},  // R3 own ID
      {4'd3,  8'h14, 16'h00AD, 8'h14, 16'h0005},  // R3 selector
      {4'd3,  8'h24, 16'h1237, 8'h24, 16'h0003},  // R3 DMA mode
      {4'd3,  8'h20, 16'hABCD, 8'h20, 16'h00CD},  // R3 data
      {4'd2,  8'h00, 16'h5A5A, 8'h00, 16'h5A5A},  // R2 diag data
      {4'd2,  8'h54, 16'h00F3, 8'h54, 16'h00F3},  // R2 diag control
      {4'd11, 8'h50, 16'hFFFF, 8'h50, 16'hBFFF},  // R11 reset request dropped
      {4'd2,  8'h0C, 16'h8000, 8'h0C, 16'h8000},  // R2 control, enable off
      {4'd4,  8'h18, 16'hFFFF, 8'h18, 16'h0005},  // R4 detector ID
      {4'd1,  8'h12, 16'h1111, 8'h10, 16'h0007},  // R1 misaligned write
      {4'd1,  8'h21, 16'h0000, 8'h20, 16'h00CD},  // R1 misaligned write
      {4'd2,  8'h30, 16'hFFFF, 8'h30, 16'h0000},  // R2 unmapped
      {4'd5,  8'h48, 16'hFFFF, 8'h48, 16'h0400},  // R5 link status
      {4'd6,  8'h4C, 16'hFFFF, 8'h4C, 16'h13E0}   // R6 transfer status
   };
   localparam int LBITS [5] = '{13, 12, 11, 9, 8};
   localparam int XBITS [3] = '{4, 11, 13};

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
      bus_addr = a;
      #2;
      chk(req, $sformatf("read %h", a), bus_rdata, exp);
   endtask

   task automatic ck_irq(input logic exp, input string req);
      #1;
      chk(req, "irq", {15'b0, irq}, {15'b0, exp});
   endtask

   task automatic pulse_link(input logic [15:0] v);
      @(negedge clk); link_set = v;
      @(negedge clk); link_set = '0;
   endtask

   task automatic pulse_xfer(input logic [15:0] v);
      @(negedge clk); xfer_set = v;
      @(negedge clk); xfer_set = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h0C, 16'h0000, "R13");
      rd(8'h48, 16'h0000, "R13");
      ck_irq(1'b0, "R13");

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][47:40], VEC[i][39:24]);
         rd(VEC[i][23:16], VEC[i][15:0], $sformatf("R%0d", VEC[i][51:48]));
      end

      // R7 R9: state change raises link summary in both words
      pulse_link(16'h0008);
      rd(8'h48, 16'h8408, "R7");
      rd(8'h4C, 16'h93E0, "R9");
      ck_irq(1'b0, "R10");
      wr(8'h0C, 16'h0001);
      ck_irq(1'b1, "R10");
      // R5: writing 0 keeps a pending event, plain bit 10 follows
      wr(8'h48, 16'h0000);
      rd(8'h48, 16'h8008, "R5");
      wr(8'h48, 16'h0008);
      rd(8'h48, 16'h0000, "R5");
      ck_irq(1'b0, "R10");
      // R5 R7: read-only bit 0 not in summary, not cleared by write
      pulse_link(16'h0001);
      rd(8'h48, 16'h0001, "R7");
      ck_irq(1'b0, "R7");
      wr(8'h48, 16'h0001);
      rd(8'h48, 16'h0001, "R5");
      // R8 R9: transmit buffer empty
      wr(8'h4C, 16'h0000);
      rd(8'h4C, 16'h0000, "R6");
      pulse_xfer(16'h0400);
      rd(8'h4C, 16'h4400, "R8");
      rd(8'h48, 16'h4001, "R9");
      ck_irq(1'b1, "R10");
      wr(8'h4C, 16'hC000);
      rd(8'h4C, 16'h4400, "R9");
      wr(8'h4C, 16'h0400);
      rd(8'h4C, 16'h0000, "R6");
      ck_irq(1'b0, "R10");
      // R8: bit 3 is not a summary source
      pulse_xfer(16'h0008);
      rd(8'h4C, 16'h0008, "R8");
      ck_irq(1'b0, "R8");
      // R12: set against clear in the same cycle
      @(negedge clk);
      xfer_set = 16'h0800; bus_addr = 8'h4C; bus_wdata = 16'h0808; bus_wr = 1'b1;
      @(negedge clk);
      xfer_set = '0; bus_wr = 1'b0;
      rd(8'h4C, 16'h4800, "R12");
      ck_irq(1'b1, "R12");
      wr(8'h4C, 16'h0800);
      rd(8'h4C, 16'h0000, "R6");

      for (int k = 0; k < 5; k++) begin
         pulse_link(16'(1) << LBITS[k]);
         rd(8'h48, (16'(1) << LBITS[k]) | 16'h8001, "R7");
         ck_irq(1'b1, "R7");
         wr(8'h48, 16'(1) << LBITS[k]);
         rd(8'h48, 16'h0001, "R5");
         ck_irq(1'b0, "R7");
      end
      for (int k = 0; k < 3; k++) begin
         pulse_xfer(16'(1) << XBITS[k]);
         rd(8'h4C, (16'(1) << XBITS[k]) | 16'h4000, "R8");
         ck_irq(1'b1, "R8");
         wr(8'h4C, 16'(1) << XBITS[k]);
         rd(8'h4C, 16'h0000, "R6");
      end

      rd(8'h49, 16'h0000, "R1");
      rd(8'h0E, 16'h0000, "R1");

      // R13: reset again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(8'h10, 16'h0000, "R13");
      rd(8'h48, 16'h0000, "R13");
      rd(8'h50, 16'h0000, "R13");
      ck_irq(1'b0, "R13");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule